// File: doc/BRIEF.md
# Downstream Port Power and Fault Manager

This block drives the power-switch enables for up to seven downstream ports of a hub and watches the overcurrent flags that the external switches return. The hub command logic requests power on or off for a port with single-cycle pulses. The block turns those pulses into active-low enable levels. Each overcurrent flag passes through a run-length filter before the block acts on it. A filtered fault cuts power to the affected port and latches a fault bit for that port.

Two straps are sampled only while reset is held. The first selects per-port or ganged power control. In ganged mode, any request or any fault acts on every supported port at once. The second selects bus-powered operation, where only the lower ports are usable, or self-powered operation, where all ports are usable. Three aggregate status lines are derived for indicator LEDs: hub configured, some port powered, and no port faulted. Each has an output-enable that drops during suspend so the pads can float. All pins are plain control and status levels, so there is no valid/ready handshake and no back-pressure.

Top module: `port_power_mgr`

## Requirements
- R1: While reset is low, and right after it is released, every `pwr_en_n_o` bit is 1 (port off) and every `fault_o` bit is 0.
- R2: A 1 on `req_on_i[i]` at a clock edge drives `pwr_en_n_o[i]` to 0 after that edge. A 1 on `req_off_i[i]` drives it to 1. When both are 1 for the same port in the same cycle, the off request wins.
- R3: An overcurrent is recognised only when `ovc_n_i[i]` is sampled 0 on FILT_CYCLES consecutive edges (default 8). The port is switched off and `fault_o[i]` is set after the edge that samples the last of those lows. A shorter low run, including a single-cycle glitch, has no effect.
- R4: A latched fault keeps the port off. A power-on request is ignored while the filtered overcurrent is still active. Once `ovc_n_i[i]` has been sampled 1 on at least one edge, a new power-on request turns the port on and clears `fault_o[i]`.
- R5: In per-port mode (ganged strap 0 at reset), requests and overcurrent inputs of one port never change another port's enable or fault bit.
- R6: In ganged mode (ganged strap 1 at reset), a request on any supported port switches all supported ports together. A filtered fault on any supported port switches all of them off and sets the fault bit of each of them.
- R7: In bus-powered mode (bus strap 1 at reset), ports BUS_PORTS and above (default ports 4 to 6) are never powered, and their overcurrent inputs are ignored. In self-powered mode, all NPORT ports are usable.
- R8: The two straps take effect only while reset is low. Changing them after reset has no effect.
- R9: Outside suspend, `led_cfg_o` equals `hub_cfg_i`.
- R10: Outside suspend, `led_anypwr_o` is 1 when at least one port is powered and 0 when all ports are off.
- R11: Outside suspend, `led_nodis_o` is 1 when no fault bit is set and 0 when any fault bit is set.
- R12: While `suspend_i` is 1, all three output-enables are 0 and the three status data lines are driven 0. Port power is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| ganged_strap_i | input | 1 | 1 selects ganged power control |
| buspwr_strap_i | input | 1 | 1 selects bus-powered operation (reduced port count) |
| hub_cfg_i | input | 1 | Hub is configured |
| suspend_i | input | 1 | Hub is in low-power suspend |
| req_on_i | input | NPORT | Per-port power-on request pulses |
| req_off_i | input | NPORT | Per-port power-off request pulses |
| ovc_n_i | input | NPORT | Active-low overcurrent flags from the switches |
| pwr_en_n_o | output | NPORT | Active-low power-switch enables |
| fault_o | output | NPORT | Latched filtered-fault bit per port |
| led_cfg_o | output | 1 | Hub-configured indicator |
| led_cfg_oe_o | output | 1 | Output-enable for led_cfg_o |
| led_anypwr_o | output | 1 | Some-port-powered indicator |
| led_anypwr_oe_o | output | 1 | Output-enable for led_anypwr_o |
| led_nodis_o | output | 1 | No-port-faulted indicator |
| led_nodis_oe_o | output | 1 | Output-enable for led_nodis_o |

## Verification
A filter counter that is not cleared by a high sample would show up at the ports as a fault bit and a powered-down port after broken runs of lows that are each shorter than FILT_CYCLES. This is visible within one filter window of the second run. A wrong mode register would show on the first request after reset as the wrong set of enables dropping, for example unsupported ports powering up or ganged ports moving alone. A fault latch that clears too early would show as a port regaining power on a request made while its flag is still held low, on the edge that samples that request.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic {
    CTL_PER_PORT = 1'b0,
    CTL_GANGED   = 1'b1
  } ctl_mode_e;
endpackage

// File: rtl/ovc_filter.sv
module ovc_filter #(
  parameter int FILT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovc_n_i,
  output logic trip_o,
  output logic over_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] run_q;
  logic          over_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      over_q <= 1'b0;
    end else if (ovc_n_i) begin
      run_q  <= '0;
      over_q <= 1'b0;
    end else if (!over_q) begin
      if (run_q == LIM) over_q <= 1'b1;
      else              run_q  <= run_q + 1'b1;
    end
  end

  assign trip_o = !ovc_n_i && !over_q && (run_q == LIM);
  assign over_o = over_q;

  // R3: a trip needs the flag low on the previous edge as well
  assert_trip_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> $past(!ovc_n_i));
endmodule

// File: rtl/port_switch_ctrl.sv
module port_switch_ctrl
  import ppm_pkg::*;
#(
  parameter int NPORT     = 7,
  parameter int BUS_PORTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ganged_strap_i,
  input  logic             buspwr_strap_i,
  input  logic [NPORT-1:0] req_on_i,
  input  logic [NPORT-1:0] req_off_i,
  input  logic [NPORT-1:0] trip_i,
  input  logic [NPORT-1:0] over_i,
  output logic [NPORT-1:0] pwr_o,
  output logic [NPORT-1:0] fault_o
);
  ctl_mode_e        mode_q;
  logic             bus_q;
  logic [NPORT-1:0] sup, trip_s, over_s, pwr_q, fault_q;
  logic             g_trip, g_off, g_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= ganged_strap_i ? CTL_GANGED : CTL_PER_PORT;
      bus_q  <= buspwr_strap_i;
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_sup
    assign sup[i] = !bus_q || (i < BUS_PORTS);
  end

  assign trip_s = trip_i & sup;
  assign over_s = over_i & sup;
  assign g_trip = |trip_s;
  assign g_off  = |(req_off_i & sup);
  assign g_on   = |(req_on_i & sup) && !(|over_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q   <= '0;
      fault_q <= '0;
    end else if (mode_q == CTL_GANGED) begin
      if (g_trip) begin
        pwr_q   <= '0;
        fault_q <= sup;
      end else if (g_off) begin
        pwr_q   <= '0;
      end else if (g_on) begin
        pwr_q   <= sup;
        fault_q <= '0;
      end
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (trip_s[i]) begin
          pwr_q[i]   <= 1'b0;
          fault_q[i] <= 1'b1;
        end else if (req_off_i[i]) begin
          pwr_q[i]   <= 1'b0;
        end else if (req_on_i[i] && sup[i] && !over_s[i]) begin
          pwr_q[i]   <= 1'b1;
          fault_q[i] <= 1'b0;
        end
      end
    end
  end

  assign pwr_o   = pwr_q;
  assign fault_o = fault_q;

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    // R4: a supported port that trips is unpowered afterwards
    assert_trip_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trip_s[i] |=> !pwr_q[i]);
    // R7: unsupported ports never carry power
    assert_unsup_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sup[i] |-> !pwr_q[i]);
  end

  // R6: ganged ports are all on or all off
  assert_gang_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CTL_GANGED) |-> ((pwr_q == '0) || (pwr_q == sup)));
endmodule

// File: rtl/port_power_mgr.sv
module port_power_mgr #(
  parameter int NPORT       = 7,
  parameter int BUS_PORTS   = 4,
  parameter int FILT_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ganged_strap_i,
  input  logic             buspwr_strap_i,
  input  logic             hub_cfg_i,
  input  logic             suspend_i,
  input  logic [NPORT-1:0] req_on_i,
  input  logic [NPORT-1:0] req_off_i,
  input  logic [NPORT-1:0] ovc_n_i,
  output logic [NPORT-1:0] pwr_en_n_o,
  output logic [NPORT-1:0] fault_o,
  output logic             led_cfg_o,
  output logic             led_cfg_oe_o,
  output logic             led_anypwr_o,
  output logic             led_anypwr_oe_o,
  output logic             led_nodis_o,
  output logic             led_nodis_oe_o
);
  logic [NPORT-1:0] trip, over, pwr, fault;

  for (genvar i = 0; i < NPORT; i++) begin : g_filt
    ovc_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ovc_n_i(ovc_n_i[i]),
      .trip_o (trip[i]),
      .over_o (over[i])
    );
  end

  port_switch_ctrl #(.NPORT(NPORT), .BUS_PORTS(BUS_PORTS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ganged_strap_i(ganged_strap_i),
    .buspwr_strap_i(buspwr_strap_i),
    .req_on_i      (req_on_i),
    .req_off_i     (req_off_i),
    .trip_i        (trip),
    .over_i        (over),
    .pwr_o         (pwr),
    .fault_o       (fault)
  );

  logic awake;
  assign awake           = !suspend_i;
  assign pwr_en_n_o      = ~pwr;
  assign fault_o         = fault;
  assign led_cfg_o       = awake && hub_cfg_i;
  assign led_anypwr_o    = awake && (|pwr);
  assign led_nodis_o     = awake && !(|fault);
  assign led_cfg_oe_o    = awake;
  assign led_anypwr_oe_o = awake;
  assign led_nodis_oe_o  = awake;

  // R11: a newly latched fault pulls the no-fault indicator low
  assert_nodis_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|fault) && !suspend_i) |-> !led_nodis_o);
endmodule

// File: tb/port_power_mgr_bench.sv
module port_power_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ganged = 1'b0, buspwr = 1'b0, hub_cfg = 1'b0, suspend = 1'b0;
  logic [NP-1:0] req_on = '0, req_off = '0, ovc_n = '1;
  logic [NP-1:0] en_n, fault;
  logic lc, lc_oe, la, la_oe, ln, ln_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_power_mgr u_port_power_mgr (
    .clk(clk), .rst_n(rst_n), .ganged_strap_i(ganged), .buspwr_strap_i(buspwr),
    .hub_cfg_i(hub_cfg), .suspend_i(suspend), .req_on_i(req_on), .req_off_i(req_off),
    .ovc_n_i(ovc_n), .pwr_en_n_o(en_n), .fault_o(fault),
    .led_cfg_o(lc), .led_cfg_oe_o(lc_oe), .led_anypwr_o(la), .led_anypwr_oe_o(la_oe),
    .led_nodis_o(ln), .led_nodis_oe_o(ln_oe)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [NP-1:0] on, logic [NP-1:0] off);
    req_on = on; req_off = off;
    step(1);
    req_on = '0; req_off = '0;
  endtask

  task automatic do_reset(logic g, logic b);
    rst_n = 1'b0; ganged = g; buspwr = b;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk("R1 enables off", en_n, 7'h7F);
    chk("R1 faults clear", fault, 7'h00);
    chk("R10 anypwr low", la, 1'b0);
    chk("R11 nodis high", ln, 1'b1);
  endtask

  task automatic t_onoff();
    pulse(7'b0001001, '0);
    chk("R2 on ports 0,3", en_n, 7'b1110110);
    chk("R10 anypwr high", la, 1'b1);
    pulse('0, 7'b0000001);
    chk("R2 off port 0", en_n, 7'b1110111);
    pulse(7'b0000001, 7'b0000001);
    chk("R2 off wins", en_n, 7'b1110111);
  endtask

  task automatic t_filter();
    ovc_n[3] = 1'b0; step(7); ovc_n[3] = 1'b1; step(1);
    chk("R3 seven lows ignored", {fault, en_n}, {7'h00, 7'b1110111});
    ovc_n[3] = 1'b0; step(1); ovc_n[3] = 1'b1; step(1);
    chk("R3 glitch ignored", {fault, en_n}, {7'h00, 7'b1110111});
    ovc_n[3] = 1'b0; step(8);
    chk("R3 eight lows trip", {fault, en_n}, {7'b0001000, 7'h7F});
    chk("R11 nodis low", ln, 1'b0);
    chk("R10 anypwr low", la, 1'b0);
  endtask

  task automatic t_latch();
    pulse(7'b0001000, '0);
    chk("R4 on ignored while low", {fault, en_n}, {7'b0001000, 7'h7F});
    ovc_n[3] = 1'b1; step(1);
    chk("R4 stays off after release", en_n, 7'h7F);
    pulse(7'b0001000, '0);
    chk("R4 new request restores", {fault, en_n}, {7'h00, 7'b1110111});
  endtask

  task automatic t_isolate();
    pulse(7'b0000110, '0);
    ovc_n[1] = 1'b0; step(8);
    chk("R5 only port 1 faults", {fault, en_n}, {7'b0000010, 7'b1110011});
    ovc_n[1] = 1'b1; step(1);
  endtask

  task automatic t_status();
    hub_cfg = 1'b1; step(1);
    chk("R9 cfg follows", lc, 1'b1);
    suspend = 1'b1; step(1);
    chk("R12 oe off", {lc_oe, la_oe, ln_oe}, 3'b000);
    chk("R12 data low", {lc, la, ln}, 3'b000);
    chk("R12 power kept", en_n, 7'b1110011);
    suspend = 1'b0; hub_cfg = 1'b0; step(1);
    chk("R9 cfg low", {lc, lc_oe}, 2'b01);
  endtask

  task automatic t_ganged();
    do_reset(1'b1, 1'b1);
    pulse(7'b0000100, '0);
    chk("R6 R7 gang on four", en_n, 7'b1110000);
    ovc_n[5] = 1'b0; step(10); ovc_n[5] = 1'b1; step(1);
    chk("R7 unsupported fault ignored", {fault, en_n}, {7'h00, 7'b1110000});
    pulse(7'b1000000, '0);
    chk("R7 unsupported request ignored", en_n, 7'b1110000);
    ovc_n[1] = 1'b0; step(8);
    chk("R6 gang trip", {fault, en_n}, {7'b0001111, 7'h7F});
    pulse(7'b0000001, '0);
    chk("R4 gang on ignored while low", en_n, 7'h7F);
    ovc_n[1] = 1'b1; step(1);
    ganged = 1'b0; buspwr = 1'b0;
    pulse(7'b0000001, '0);
    chk("R8 straps held", {fault, en_n}, {7'h00, 7'b1110000});
    pulse('0, 7'b0001000);
    chk("R6 gang off", en_n, 7'h7F);
  endtask

  initial begin
    step(1);
    t_reset();
    t_onoff();
    t_filter();
    t_latch();
    t_isolate();
    t_status();
    t_ganged();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule